// File: doc/BRIEF.md
# I2C Target with Masked Address Compare

This block is the target (slave) side of an I2C bus. Both bus lines are sampled by the system clock through a short synchronizer, and edge detection then happens in that clock domain. The block finds START and STOP conditions and raises a sticky flag for each one. It checks the first byte of a transfer against an own-address register, and a companion mask register marks which address bits are ignored. It acknowledges by pulling SDA low. Received bytes pass through a hidden shift register into a readable buffer. In read transfers it shifts out a byte that software has loaded.

Seven-bit or ten-bit addressing is chosen by a control bit. In ten-bit mode the header byte carries the pattern `11110`, the two upper address bits and the direction bit, and a second byte carries the low eight bits. A ten-bit read is accepted only after a repeated START that follows a complete ten-bit write match. A small word-wide register port exposes control, status, data, address and mask. A single interrupt line is the OR of the pending status flags.

Top module: `i2c_mask_slave`

Register map (3-bit index, 8-bit data):
- 0 control: bit0 enable, bit1 ten-bit mode.
- 1 status: bit0 START seen, bit1 STOP seen, bit2 receive buffer full, bit3 overflow, bit4 address byte accepted, bit5 transmitting. Writing 1 clears bits 0, 1, 3 and 4.
- 2 data: a read returns the receive buffer and clears bit2 of status. A write loads the transmit byte.
- 3 address low (seven-bit mode uses bits 6:0), 4 address high (bits 1:0).
- 5 mask low, 6 mask high. A mask bit of 1 means the bit is compared. Both masks reset to all ones, and all other registers reset to zero.

## Requirements
- R1: After reset the status reads 0, control reads 0, mask low reads 0xFF, `irq` is 0 and `sda_oe` is 0.
- R2: With control bit0 clear, the block never drives SDA and sets no status flag, whatever happens on the bus.
- R3: A START (SDA falls while SCL is high) sets status bit0 and a STOP (SDA rises while SCL is high) sets status bit1, whether or not the address matches. `irq` is high while any of status bits 0 to 4 is set, and writing 1 to a flag clears it.
- R4: In seven-bit mode the first byte's bits 7:1 are acknowledged when `((rx ^ addr_lo) & mask_lo)` is 0 over bits 6:0, and are otherwise not acknowledged.
- R5: A first byte of 0x00 (general call) is never acknowledged, even when the mask would let it match.
- R6: A data byte written to a matched target is acknowledged, stored in the receive buffer and sets status bit2. Reading the data register clears bit2.
- R7: If a data byte completes while status bit2 is still set, status bit3 is set, the byte is not acknowledged and the receive buffer keeps its previous value.
- R8: After an accepted read address, the transmit byte is shifted out MSB first, one bit per SCL low phase. It is reloaded for each byte the controller acknowledges, and status bit5 is set while transmitting.
- R9: A NACK from the controller after a transmitted byte ends the transmission, and SDA stays released until the next START.
- R10: In ten-bit mode a header `11110 a9 a8 0` whose a9:a8 match under mask high is acknowledged and sets status bit4. A second byte matching address low under mask low is acknowledged, and data then flows as in R6. Any other header or low byte is not acknowledged.
- R11: In ten-bit mode a header with direction bit 1 is acknowledged only after a repeated START that follows a full ten-bit match, and a STOP cancels that match.
- R12: `sda_oe` changes only while SCL is low, so SDA is stable whenever SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (data read clears buffer full) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | OR of status bits 0 to 4 |

## Verification
The assertions check on every cycle that SDA is released while the block is disabled or idle, that the drive only changes during SCL low, that general call and overflow never produce an ACK, that a stored byte leaves the buffer full, and that a START always leaves its flag set. The bench scenarios are the only place the masked address arithmetic is shown over all 128 seven-bit addresses. The same holds for the exact serial order of transmitted bits, the ten-bit header and low-byte sequence, the repeated-START read rule, and the clearing of flags through the register port.

// File: rtl/i2c_msk_pkg.sv
package i2c_msk_pkg;

  localparam int BYTE_W   = 8;
  localparam int ADDR10_W = 10;
  localparam int REG_AW   = 3;
  localparam int BIT_CNT_W = 4;
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR1 = 3'd1,
    PH_ADDR2 = 3'd2,
    PH_RX    = 3'd3,
    PH_TX    = 3'd4
  } phase_t;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd2;
  localparam logic [REG_AW-1:0] RA_ALO  = 3'd3;
  localparam logic [REG_AW-1:0] RA_AHI  = 3'd4;
  localparam logic [REG_AW-1:0] RA_MLO  = 3'd5;
  localparam logic [REG_AW-1:0] RA_MHI  = 3'd6;

  // True when every bit selected by msk agrees between rx and own.
  function automatic logic masked_eq(input logic [ADDR10_W-1:0] rx,
                                     input logic [ADDR10_W-1:0] own,
                                     input logic [ADDR10_W-1:0] msk);
    return ((rx ^ own) & msk) == '0;
  endfunction

  // Bit to present after 'sent' bits have already gone out, MSB first.
  function automatic logic pick_tx_bit(input logic [BYTE_W-1:0] d,
                                       input logic [BIT_CNT_W-1:0] sent);
    logic [2:0] p;
    p = 3'(4'd7 - sent);
    return d[p];
  endfunction

endpackage

// File: rtl/i2c_msk_sync.sv
module i2c_msk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  // Idle bus level is high; pipe[STAGES] holds the previous synced value.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2c_msk_match.sv
module i2c_msk_match
  import i2c_msk_pkg::*;
(
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic [ADDR10_W-1:0] own_addr,
  input  logic [ADDR10_W-1:0] own_mask,
  output logic                hit7,
  output logic                hdr_hit,
  output logic                lo_hit,
  output logic                gen_call
);
  localparam int PAD7 = ADDR10_W - 7;
  localparam int PAD2 = ADDR10_W - 2;
  localparam int PAD8 = ADDR10_W - BYTE_W;

  assign hit7 = masked_eq({{PAD7{1'b0}}, rx_byte[7:1]},
                          {{PAD7{1'b0}}, own_addr[6:0]},
                          {{PAD7{1'b0}}, own_mask[6:0]});

  assign hdr_hit = (rx_byte[7:3] == HDR10) &&
                   masked_eq({{PAD2{1'b0}}, rx_byte[2:1]},
                             {{PAD2{1'b0}}, own_addr[9:8]},
                             {{PAD2{1'b0}}, own_mask[9:8]});

  assign lo_hit = masked_eq({{PAD8{1'b0}}, rx_byte},
                            {{PAD8{1'b0}}, own_addr[7:0]},
                            {{PAD8{1'b0}}, own_mask[7:0]});

  assign gen_call = (rx_byte == '0);
endmodule

// File: rtl/i2c_msk_regs.sv
module i2c_msk_regs
  import i2c_msk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  input  logic                start_evt,
  input  logic                stop_evt,
  input  logic                store_evt,
  input  logic                ovf_evt,
  input  logic                upd_evt,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                xmit,
  output logic                en,
  output logic                ten_bit,
  output logic [ADDR10_W-1:0] own_addr,
  output logic [ADDR10_W-1:0] own_mask,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                buf_full,
  output logic [BYTE_W-1:0]   rx_buf,
  output logic                start_flag,
  output logic                irq
);
  logic [1:0]        ctrl_q;
  logic              f_stop, f_ovf, f_upd;
  logic [BYTE_W-1:0] alo_q, mlo_q;
  logic [1:0]        ahi_q, mhi_q;
  logic              wr_stat, wr_hit, rd_data;

  assign wr_stat = reg_we && (reg_addr == RA_STAT);
  assign rd_data = reg_re && (reg_addr == RA_DATA);
  assign wr_hit  = reg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      start_flag <= 1'b0;
      f_stop     <= 1'b0;
      buf_full   <= 1'b0;
      f_ovf      <= 1'b0;
      f_upd      <= 1'b0;
      rx_buf     <= '0;
      tx_byte    <= '0;
      alo_q      <= '0;
      ahi_q      <= '0;
      mlo_q      <= '1;
      mhi_q      <= '1;
    end else begin
      // Events from the bus take priority over software clears.
      start_flag <= start_evt | (start_flag & ~(wr_stat & reg_wdata[0]));
      f_stop     <= stop_evt  | (f_stop     & ~(wr_stat & reg_wdata[1]));
      f_ovf      <= ovf_evt   | (f_ovf      & ~(wr_stat & reg_wdata[3]));
      f_upd      <= upd_evt   | (f_upd      & ~(wr_stat & reg_wdata[4]));
      buf_full   <= store_evt | (buf_full   & ~rd_data);
      if (store_evt) rx_buf <= rx_byte;
      if (wr_hit) begin
        case (reg_addr)
          RA_CTRL: ctrl_q  <= reg_wdata[1:0];
          RA_DATA: tx_byte <= reg_wdata;
          RA_ALO:  alo_q   <= reg_wdata;
          RA_AHI:  ahi_q   <= reg_wdata[1:0];
          RA_MLO:  mlo_q   <= reg_wdata;
          RA_MHI:  mhi_q   <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata = {6'b0, ctrl_q};
      RA_STAT: reg_rdata = {2'b0, xmit, f_upd, f_ovf, buf_full, f_stop, start_flag};
      RA_DATA: reg_rdata = rx_buf;
      RA_ALO:  reg_rdata = alo_q;
      RA_AHI:  reg_rdata = {6'b0, ahi_q};
      RA_MLO:  reg_rdata = mlo_q;
      RA_MHI:  reg_rdata = {6'b0, mhi_q};
      default: reg_rdata = '0;
    endcase
  end

  assign en       = ctrl_q[0];
  assign ten_bit  = ctrl_q[1];
  assign own_addr = {ahi_q, alo_q};
  assign own_mask = {mhi_q, mlo_q};
  assign irq      = start_flag | f_stop | buf_full | f_ovf | f_upd;
endmodule

// File: rtl/i2c_mask_slave.sv
module i2c_mask_slave
  import i2c_msk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NLINES = 2;
  localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] ACK_DONE = BIT_CNT_W'(BYTE_W + 1);

  // ---------------- line synchronizers (index 0 = SCL, 1 = SDA)
  logic [NLINES-1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_msk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (line_in[g]),
      .level (line_lvl[g]),
      .rise  (line_rise[g]),
      .fall  (line_fall[g])
    );
  end

  logic scl_q, sda_q, scl_rise, scl_fall;
  assign scl_q    = line_lvl[0];
  assign sda_q    = line_lvl[1];
  assign scl_rise = line_rise[0];
  assign scl_fall = line_fall[0];

  // ---------------- register block
  logic                en, ten_bit, buf_full, start_flag, xmit;
  logic [ADDR10_W-1:0] own_addr, own_mask;
  logic [BYTE_W-1:0]   tx_byte, rx_buf;
  logic                start_evt, stop_evt, store_evt, ovf_evt, upd_evt;

  // ---------------- protocol state
  phase_t               phase, nxt_q, decide_nxt, after_ack;
  logic [BIT_CNT_W-1:0] cnt;
  logic [BYTE_W-1:0]    sh, tx_q;
  logic                 oe_q, m_nack, ten_ok;
  logic                 hit7, hdr_hit, lo_hit, gen_call;
  logic                 ack_dec, want_store, want_ovf, want_upd, want_ten;
  logic                 byte_evt, ack_now, gc_evt, idle;

  i2c_msk_match u_match (
    .rx_byte  (sh),
    .own_addr (own_addr),
    .own_mask (own_mask),
    .hit7     (hit7),
    .hdr_hit  (hdr_hit),
    .lo_hit   (lo_hit),
    .gen_call (gen_call)
  );

  // Named bus events
  assign start_evt = en & line_fall[1] & scl_q;
  assign stop_evt  = en & line_rise[1] & scl_q;
  assign byte_evt  = en & ~start_evt & ~stop_evt & scl_fall & (cnt == ACK_SLOT) &
                     (phase != PH_IDLE) & (phase != PH_TX);

  // Decision taken when the eighth bit of a received byte has been clocked.
  always_comb begin
    ack_dec    = 1'b0;
    decide_nxt = PH_IDLE;
    want_store = 1'b0;
    want_ovf   = 1'b0;
    want_upd   = 1'b0;
    want_ten   = 1'b0;
    case (phase)
      PH_ADDR1: begin
        if (!ten_bit) begin
          if (hit7 && !gen_call) begin
            ack_dec    = 1'b1;
            decide_nxt = sh[0] ? PH_TX : PH_RX;
          end
        end else if (hdr_hit) begin
          if (!sh[0]) begin
            ack_dec    = 1'b1;
            want_upd   = 1'b1;
            decide_nxt = PH_ADDR2;
          end else if (ten_ok) begin
            ack_dec    = 1'b1;
            want_upd   = 1'b1;
            decide_nxt = PH_TX;
          end
        end
      end
      PH_ADDR2: begin
        if (lo_hit) begin
          ack_dec    = 1'b1;
          want_upd   = 1'b1;
          want_ten   = 1'b1;
          decide_nxt = PH_RX;
        end
      end
      PH_RX: begin
        decide_nxt = PH_RX;
        if (buf_full) want_ovf = 1'b1;
        else begin
          ack_dec    = 1'b1;
          want_store = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign ack_now   = byte_evt & ack_dec;
  assign store_evt = byte_evt & want_store;
  assign ovf_evt   = byte_evt & want_ovf;
  assign upd_evt   = byte_evt & want_upd;
  assign gc_evt    = byte_evt & (phase == PH_ADDR1) & ~ten_bit & gen_call;
  assign after_ack = (phase == PH_TX) ? (m_nack ? PH_IDLE : PH_TX) : nxt_q;
  assign idle      = (phase == PH_IDLE);
  assign xmit      = (phase == PH_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      nxt_q  <= PH_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      m_nack <= 1'b0;
      ten_ok <= 1'b0;
    end else if (!en) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      oe_q   <= 1'b0;
      ten_ok <= 1'b0;
    end else if (start_evt) begin
      phase <= PH_ADDR1;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      oe_q   <= 1'b0;
      ten_ok <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (cnt < ACK_SLOT) begin
          sh  <= {sh[BYTE_W-2:0], sda_q};
          cnt <= cnt + 1'b1;
        end else if (cnt == ACK_SLOT) begin
          cnt <= ACK_DONE;
          if (phase == PH_TX) m_nack <= sda_q;
        end
      end else if (scl_fall) begin
        if (cnt == ACK_SLOT) begin
          if (phase == PH_TX) oe_q <= 1'b0;
          else begin
            oe_q  <= ack_dec;
            nxt_q <= decide_nxt;
            if (want_ten) ten_ok <= 1'b1;
          end
        end else if (cnt == ACK_DONE) begin
          cnt   <= '0;
          phase <= after_ack;
          if (after_ack == PH_TX) begin
            tx_q <= tx_byte;
            oe_q <= ~tx_byte[BYTE_W-1];
          end else begin
            oe_q <= 1'b0;
          end
        end else if (phase == PH_TX && cnt != '0) begin
          oe_q <= ~pick_tx_bit(tx_q, cnt);
        end
      end
    end
  end

  assign sda_oe = oe_q;

  i2c_msk_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .store_evt  (store_evt),
    .ovf_evt    (ovf_evt),
    .upd_evt    (upd_evt),
    .rx_byte    (sh),
    .xmit       (xmit),
    .en         (en),
    .ten_bit    (ten_bit),
    .own_addr   (own_addr),
    .own_mask   (own_mask),
    .tx_byte    (tx_byte),
    .buf_full   (buf_full),
    .rx_buf     (rx_buf),
    .start_flag (start_flag),
    .irq        (irq)
  );
endmodule

// File: rtl/i2c_msk_chk.sv
module i2c_msk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       sda_oe,
  input logic       scl_q,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       ack_now,
  input logic       gc_evt,
  input logic       store_evt,
  input logic       ovf_evt,
  input logic [7:0] rx_buf,
  input logic       buf_full,
  input logic       start_flag,
  input logic       idle
);
  AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_oe); // R2

  AST_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> start_flag); // R3

  AST_GC_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    gc_evt |-> !ack_now); // R5

  AST_FULL_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> buf_full); // R6

  AST_OVF_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !ack_now); // R7

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> $stable(rx_buf)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle)) |-> !sda_oe); // R9

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(start_evt) && !$past(stop_evt) && !$stable(sda_oe))
      |-> !$past(scl_q)); // R12
endmodule

bind i2c_mask_slave i2c_msk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .sda_oe     (sda_oe),
  .scl_q      (scl_q),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .ack_now    (ack_now),
  .gc_evt     (gc_evt),
  .store_evt  (store_evt),
  .ovf_evt    (ovf_evt),
  .rx_buf     (rx_buf),
  .buf_full   (buf_full),
  .start_flag (start_flag),
  .idle       (idle)
);

// File: tb/sim_i2c_mask_slave.sv
`timescale 1ns/100ps
module sim_i2c_mask_slave;
  localparam int Q = 6;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2,
                         A_ALO = 3'd3, A_AHI = 3'd4, A_MLO = 3'd5, A_MHI = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] ra = '0;
  logic [7:0] wd = '0;
  wire  [7:0] rd;
  wire        oe, irq;
  wire        sda_line = msda & ~oe;
  int total = 0, bad = 0, viol = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mask_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(oe),
    .reg_we(we), .reg_re(re), .reg_addr(ra), .reg_wdata(wd), .reg_rdata(rd), .irq(irq)
  );

  // R12 monitor: the drive must not move while SCL is high.
  always @(posedge clk) begin
    #1;
    if (rst_n && scl && (oe !== oe_prev)) viol++;
    oe_prev = oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); ra = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; re = 1'b1; #1 d = rd;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic start_c();
    msda = 1'b1; tick(Q); scl = 1'b1; tick(Q); msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    msda = 1'b0; tick(Q); scl = 1'b1; tick(Q); msda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    msda = b; tick(Q); scl = 1'b1; tick(Q); s = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic ack, exp_ack;
    tick(4); rst_n = 1'b1; tick(4);

    // R1 reset state
    rreg(A_STAT, v); chk("R1 status", v, 8'h00);
    rreg(A_CTRL, v); chk("R1 control", v, 8'h00);
    rreg(A_MLO, v);  chk("R1 mask low", v, 8'hFF);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sda_oe", oe, 1'b0);

    // R2 disabled: no ACK, no flags
    wreg(A_ALO, 8'h2A);
    start_c(); wr_byte(8'h54, ack); stop_c();
    chk("R2 no ack while disabled", ack, 1'b0);
    rreg(A_STAT, v); chk("R2 no flags while disabled", v, 8'h00);

    // R4 sweep of all 7-bit addresses, bits 1:0 masked out
    wreg(A_CTRL, 8'h01); wreg(A_MLO, 8'h7C);
    for (int a = 0; a < 128; a++) begin
      start_c(); wr_byte({7'(a), 1'b0}, ack); stop_c();
      exp_ack = (((a ^ 'h2A) & 'h7C) == 0) && (a != 0);
      chk($sformatf("R4 addr %0h", a), ack, exp_ack);
    end

    // R3 flags from unmatched traffic, irq and write-1 clear
    rreg(A_STAT, v); chk("R3 start+stop flags", v & 8'h03, 8'h03);
    chk("R3 irq set", irq, 1'b1);
    wreg(A_STAT, 8'h03);
    rreg(A_STAT, v); chk("R3 flags cleared", v, 8'h00);
    chk("R3 irq clear", irq, 1'b0);

    // R5 general call refused even with a mask of zero
    wreg(A_ALO, 8'h00); wreg(A_MLO, 8'h00);
    start_c(); wr_byte(8'h00, ack); stop_c();
    chk("R5 general call nack", ack, 1'b0);
    start_c(); wr_byte(8'h0A, ack); stop_c();
    chk("R5 wildcard match acks", ack, 1'b1);

    // R6 / R7 receive and overflow
    wreg(A_ALO, 8'h2A); wreg(A_MLO, 8'h7F); wreg(A_STAT, 8'hFF);
    start_c(); wr_byte(8'h54, ack); chk("R6 address ack", ack, 1'b1);
    wr_byte(8'hC3, ack); chk("R6 data ack", ack, 1'b1);
    rreg(A_STAT, v); chk("R6 full set", v[2], 1'b1);
    rreg(A_DATA, v); chk("R6 buffer value", v, 8'hC3);
    rreg(A_STAT, v); chk("R6 full cleared by read", v[2], 1'b0);
    wr_byte(8'h5A, ack); chk("R6 second byte ack", ack, 1'b1);
    wr_byte(8'h11, ack); chk("R7 overflow nack", ack, 1'b0);
    rreg(A_STAT, v); chk("R7 overflow flag", v[3], 1'b1);
    rreg(A_DATA, v); chk("R7 buffer kept", v, 8'h5A);
    stop_c();
    wreg(A_STAT, 8'hFF);

    // R8 / R9 transmit
    wreg(A_DATA, 8'hA5);
    start_c(); wr_byte(8'h55, ack); chk("R8 read address ack", ack, 1'b1);
    rreg(A_STAT, v); chk("R8 transmitting flag", v[5], 1'b1);
    rd_byte(1'b1, v); chk("R8 first byte", v, 8'hA5);
    rd_byte(1'b0, v); chk("R8 reloaded byte", v, 8'hA5);
    rd_byte(1'b1, v); chk("R9 released after nack", v, 8'hFF);
    rreg(A_STAT, v); chk("R9 transmit ended", v[5], 1'b0);
    stop_c();
    wreg(A_DATA, 8'h3C);
    start_c(); wr_byte(8'h55, ack); rd_byte(1'b0, v); stop_c();
    chk("R8 second pattern", v, 8'h3C);

    // R10 ten-bit write
    wreg(A_CTRL, 8'h03); wreg(A_ALO, 8'h5C); wreg(A_AHI, 8'h02);
    wreg(A_MLO, 8'hFF); wreg(A_MHI, 8'h03); wreg(A_STAT, 8'hFF);
    rreg(A_DATA, v);
    start_c(); wr_byte(8'hF4, ack); chk("R10 header ack", ack, 1'b1);
    rreg(A_STAT, v); chk("R10 address flag", v[4], 1'b1);
    wr_byte(8'h5C, ack); chk("R10 low byte ack", ack, 1'b1);
    wr_byte(8'h77, ack); chk("R10 data ack", ack, 1'b1);
    stop_c();
    rreg(A_DATA, v); chk("R10 data stored", v, 8'h77);
    start_c(); wr_byte(8'hF4, ack); wr_byte(8'h5D, ack); stop_c();
    chk("R10 low mismatch nack", ack, 1'b0);
    start_c(); wr_byte(8'hF6, ack); stop_c();
    chk("R10 header mismatch nack", ack, 1'b0);
    start_c(); wr_byte(8'hB8, ack); stop_c();
    chk("R10 seven-bit form refused", ack, 1'b0);
    wreg(A_MLO, 8'hFE);
    start_c(); wr_byte(8'hF4, ack); wr_byte(8'h5D, ack); stop_c();
    chk("R10 masked low bit ack", ack, 1'b1);

    // R11 ten-bit read only after full match and repeated START
    start_c(); wr_byte(8'hF5, ack); stop_c();
    chk("R11 read header without match", ack, 1'b0);
    start_c(); wr_byte(8'hF4, ack); wr_byte(8'h5C, ack);
    start_c(); wr_byte(8'hF5, ack); chk("R11 read header after match", ack, 1'b1);
    rd_byte(1'b0, v); stop_c();
    chk("R11 ten-bit read data", v, 8'h3C);

    // R12 drive only changes with SCL low
    chk("R12 drive changes while SCL high", viol, 0);

    finish_run();
  end
endmodule